// File: doc/BRIEF.md
# Sector Write-Protection and Lock Unit

This block decides, one request at a time, whether a program or erase aimed at one 64 KB sector of a 256-sector flash array may go ahead. Two independent mechanisms can forbid it. The first is a protected region whose size is a power of two, chosen by a four-bit block-protect field in the status register, and anchored at either the top or the bottom of the array. The second is a per-sector lock register with two bits. One bit is a write lock. The other is a lock-down bit that freezes the write lock until the next power-on reset.

The block also owns the status register. A status-write-disable bit, together with an active-low write-protect pin, can refuse writes to that register. This freezes the protected region in hardware.

Requests arrive as a sector index with program, erase and bulk-erase strobes. Every request is answered one clock later by a single grant or deny pulse. A denial also sets a sticky protection-error flag, which only a clear-flags strobe or a reset removes. The serial command decoder and the array itself sit outside this block.

Top module: `sector_guard`

## Requirements
- R1: The block-protect value `st_bp` selects the region size. A value of 0 protects no sector. A value n from 1 to 8 protects 2^(n-1) sectors. Any value from 9 to 15 protects all 256 sectors.
- R2: With `st_tb` = 0, the region is the highest sectors and ends at sector 255. With `st_tb` = 1, the region is the lowest sectors and starts at sector 0.
- R3: A cycle with `op_prog` or `op_erase` high answers with exactly one of `op_grant` / `op_deny` pulsing for one cycle after the next rising edge. Deny is given when the sector lies in the region or its write lock is set. No pulse appears without a request.
- R4: A sector whose write-lock bit (lock bit 0) is 1 is denied, even when the region does not cover it.
- R5: A lock write (`lk_wr`, data bit 0 = write lock, bit 1 = lock-down) ORs the lock-down bit into the stored one, so lock-down can never be cleared by a write. The write-lock bit takes the new value only while the stored lock-down bit is 0. The result is visible on `lk_rd_data` after the next edge.
- R6: A status write (`sr_wr`) is refused when the stored `st_swd` is 1 and `wp_n` is low. A refusal leaves the status unchanged and pulses `sr_refuse` one cycle later. Otherwise the new value appears after the next edge.
- R7: `op_bulk` takes precedence over the sector strobes. It is denied when the region is non-empty or any sector's write lock is set, and granted otherwise.
- R8: A denial sets `prot_err` in the same cycle the deny pulse appears. The flag then stays set until `clr_flags`. A denial and a `clr_flags` in the same cycle leave the flag set.
- R9: `soft_rst` clears `prot_err`. In its cycle, every request and write strobe is ignored. Lock bits and the status register are untouched.
- R10: A decision uses the lock and status state from before any lock or status write in the same cycle.
- R11: `por_n` low clears the status register, every lock bit and the flag. The block leaves reset two rising edges after `por_n` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| soft_rst | input | 1 | Synchronous soft reset; clears the error flag only |
| wp_n | input | 1 | Write-protect pin, active low |
| op_prog | input | 1 | Program request for `op_sector` |
| op_erase | input | 1 | Sector erase request for `op_sector` |
| op_bulk | input | 1 | Whole-array erase request |
| op_sector | input | 8 | Target sector of a program or erase |
| clr_flags | input | 1 | Clears the protection-error flag |
| sr_wr | input | 1 | Status register write strobe |
| sr_wr_bp | input | 4 | New block-protect value |
| sr_wr_tb | input | 1 | New top/bottom select |
| sr_wr_swd | input | 1 | New status-write-disable bit |
| lk_wr | input | 1 | Lock register write strobe |
| lk_sector | input | 8 | Sector whose lock register is written |
| lk_wr_data | input | 2 | Lock write value: bit 0 write lock, bit 1 lock-down |
| lk_rd_sector | input | 8 | Sector whose lock register is shown |
| lk_rd_data | output | 2 | Lock register of `lk_rd_sector` |
| st_bp | output | 4 | Stored block-protect value |
| st_tb | output | 1 | Stored top/bottom select |
| st_swd | output | 1 | Stored status-write-disable bit |
| sr_refuse | output | 1 | Pulse: the last status write was refused |
| op_grant | output | 1 | Pulse: the last request may proceed |
| op_deny | output | 1 | Pulse: the last request is refused |
| prot_err | output | 1 | Sticky protection-error flag |

## Verification
Grant, deny, refusal and the error flag are all registered. Each is due at the first rising edge after its strobe and holds until the following edge. The status and lock readbacks change at that same edge.

The bench drives every stimulus just after a falling edge and computes the expected results from its model state as it stood before that stimulus. It waits for the rising edge, updates the model, and compares at the next falling edge, so each comparison lands in the one cycle the result is due.

After a power-on reset the bench waits for the two-edge release before it checks or drives anything.

// File: rtl/sg_pkg.sv
package sg_pkg;

  localparam int BP_W      = 4;
  localparam int LK_WL_BIT = 0;
  localparam int LK_LD_BIT = 1;

  typedef struct packed {
    logic [BP_W-1:0] bp;
    logic            tb;
    logic            swd;
  } status_t;

  // Number of protected sectors for a block-protect code.
  function automatic int unsigned region_count(logic [BP_W-1:0] bp, int unsigned sect_w);
    int unsigned n;
    n = int'(bp);
    if (n == 0)               return 0;
    else if (n - 1 >= sect_w) return 1 << sect_w;
    else                      return 1 << (n - 1);
  endfunction

endpackage

// File: rtl/sg_rst_sync.sv
module sg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n = s2_q;
endmodule

// File: rtl/sg_region_decode.sv
module sg_region_decode import sg_pkg::*; #(
  parameter int SECT_W = 8
) (
  input  logic [BP_W-1:0]   bp,
  input  logic              tb,
  input  logic [SECT_W-1:0] sector,
  output logic              hit,
  output logic              any
);
  localparam int CW    = SECT_W + 1;
  localparam int NSECT = 1 << SECT_W;
  localparam logic [CW-1:0] NSECT_X = CW'(NSECT);

  logic [CW-1:0] cnt;
  logic [CW-1:0] sec_x;
  logic [CW-1:0] top_base;

  always_comb begin
    cnt      = CW'(region_count(bp, SECT_W));
    sec_x    = {1'b0, sector};
    top_base = NSECT_X - cnt;
    any      = (cnt != '0);
    if (tb) hit = (sec_x < cnt);
    else    hit = (sec_x >= top_base) && any;
  end
endmodule

// File: rtl/sg_status_reg.sv
module sg_status_reg import sg_pkg::*; (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_en,
  input  status_t wr_val,
  input  logic    wp_n,
  output status_t st,
  output logic    refuse
);
  status_t st_q, st_d;
  logic    ref_q, ref_d;
  logic    blocked;
  logic    st_en;

  always_comb begin
    blocked = st_q.swd & ~wp_n;
    st_en   = wr_en & ~blocked;
    ref_d   = wr_en & blocked;
    st_d    = st_en ? wr_val : st_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      ref_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ref_q <= ref_d;
    end
  end

  assign st     = st_q;
  assign refuse = ref_q;
endmodule

// File: rtl/sg_lock_bank.sv
module sg_lock_bank import sg_pkg::*; #(
  parameter int SECT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SECT_W-1:0] wr_sector,
  input  logic [1:0]        wr_val,
  input  logic [SECT_W-1:0] sel_sector,
  input  logic [SECT_W-1:0] rd_sector,
  output logic              sel_wl,
  output logic [1:0]        rd_val,
  output logic              any_wl
);
  localparam int NSECT = 1 << SECT_W;

  logic [NSECT-1:0] wl_q;
  logic [NSECT-1:0] ld_q;

  for (genvar g = 0; g < NSECT; g++) begin : g_sect
    logic en;
    logic wl_d, ld_d;

    always_comb begin
      en   = wr_en && (wr_sector == SECT_W'(g));
      ld_d = ld_q[g] | wr_val[LK_LD_BIT];
      wl_d = ld_q[g] ? wl_q[g] : wr_val[LK_WL_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wl_q[g] <= 1'b0;
        ld_q[g] <= 1'b0;
      end else if (en) begin
        wl_q[g] <= wl_d;
        ld_q[g] <= ld_d;
      end
    end
  end

  always_comb begin
    sel_wl            = wl_q[sel_sector];
    rd_val            = '0;
    rd_val[LK_WL_BIT] = wl_q[rd_sector];
    rd_val[LK_LD_BIT] = ld_q[rd_sector];
    any_wl            = |wl_q;
  end
endmodule

// File: rtl/sector_guard.sv
module sector_guard import sg_pkg::*; #(
  parameter int SECT_W = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              soft_rst,
  input  logic              wp_n,
  input  logic              op_prog,
  input  logic              op_erase,
  input  logic              op_bulk,
  input  logic [SECT_W-1:0] op_sector,
  input  logic              clr_flags,
  input  logic              sr_wr,
  input  logic [BP_W-1:0]   sr_wr_bp,
  input  logic              sr_wr_tb,
  input  logic              sr_wr_swd,
  input  logic              lk_wr,
  input  logic [SECT_W-1:0] lk_sector,
  input  logic [1:0]        lk_wr_data,
  input  logic [SECT_W-1:0] lk_rd_sector,
  output logic [1:0]        lk_rd_data,
  output logic [BP_W-1:0]   st_bp,
  output logic              st_tb,
  output logic              st_swd,
  output logic              sr_refuse,
  output logic              op_grant,
  output logic              op_deny,
  output logic              prot_err
);
  logic    rst_n;
  status_t st;
  status_t sr_new;
  logic    region_hit, region_any;
  logic    sel_wl, any_wl;
  logic    req_sec, req_bulk, sr_en, lk_en;
  logic    deny_d, grant_d, err_d;
  logic    deny_q, grant_q, err_q;

  sg_rst_sync i_rst (
    .clk    (clk),
    .arst_n (por_n),
    .rst_n  (rst_n)
  );

  always_comb begin
    req_bulk   = op_bulk & ~soft_rst;
    req_sec    = (op_prog | op_erase) & ~op_bulk & ~soft_rst;
    sr_en      = sr_wr & ~soft_rst;
    lk_en      = lk_wr & ~soft_rst;
    sr_new.bp  = sr_wr_bp;
    sr_new.tb  = sr_wr_tb;
    sr_new.swd = sr_wr_swd;
  end

  sg_status_reg i_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (sr_en),
    .wr_val (sr_new),
    .wp_n   (wp_n),
    .st     (st),
    .refuse (sr_refuse)
  );

  sg_region_decode #(.SECT_W(SECT_W)) i_region (
    .bp     (st.bp),
    .tb     (st.tb),
    .sector (op_sector),
    .hit    (region_hit),
    .any    (region_any)
  );

  sg_lock_bank #(.SECT_W(SECT_W)) i_locks (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (lk_en),
    .wr_sector  (lk_sector),
    .wr_val     (lk_wr_data),
    .sel_sector (op_sector),
    .rd_sector  (lk_rd_sector),
    .sel_wl     (sel_wl),
    .rd_val     (lk_rd_data),
    .any_wl     (any_wl)
  );

  // Decision and flag next state
  always_comb begin
    if (req_bulk) deny_d = region_any | any_wl;
    else          deny_d = req_sec & (region_hit | sel_wl);
    grant_d = (req_sec | req_bulk) & ~deny_d;
    if (soft_rst)       err_d = 1'b0;
    else if (deny_d)    err_d = 1'b1;
    else if (clr_flags) err_d = 1'b0;
    else                err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deny_q  <= 1'b0;
      grant_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      deny_q  <= deny_d;
      grant_q <= grant_d;
      err_q   <= err_d;
    end
  end

  assign op_deny  = deny_q;
  assign op_grant = grant_q;
  assign prot_err = err_q;
  assign st_bp    = st.bp;
  assign st_tb    = st.tb;
  assign st_swd   = st.swd;
endmodule

// File: rtl/sg_checker.sv
module sg_checker import sg_pkg::*; #(
  parameter int SECT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              wp_n,
  input logic              op_prog,
  input logic              op_erase,
  input logic              op_bulk,
  input logic              clr_flags,
  input logic              sr_wr,
  input logic [SECT_W-1:0] lk_rd_sector,
  input logic [1:0]        lk_rd_data,
  input logic [BP_W-1:0]   st_bp,
  input logic              st_tb,
  input logic              st_swd,
  input logic              sr_refuse,
  input logic              op_grant,
  input logic              op_deny,
  input logic              prot_err
);
  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_grant && op_deny)); // R3
  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (op_prog || op_erase || op_bulk) && !soft_rst |=> (op_grant || op_deny)); // R3
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_prog || op_erase || op_bulk) |=> !op_grant && !op_deny); // R3
  AST_DENY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    op_deny |-> prot_err); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err && !clr_flags && !soft_rst |=> prot_err); // R8
  AST_LOCKDOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lk_rd_data[LK_LD_BIT] |=> (lk_rd_sector != $past(lk_rd_sector)) || lk_rd_data[LK_LD_BIT]); // R5
  AST_WLOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lk_rd_data[LK_LD_BIT] |=> (lk_rd_sector != $past(lk_rd_sector)) ||
                              (lk_rd_data[LK_WL_BIT] == $past(lk_rd_data[LK_WL_BIT]))); // R5
  AST_STATUS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    st_swd && !wp_n |=> $stable({st_bp, st_tb, st_swd})); // R6
  AST_STATUS_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr && !soft_rst && st_swd && !wp_n |=> sr_refuse); // R6
  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !prot_err); // R9
endmodule

bind sector_guard sg_checker #(.SECT_W(SECT_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .soft_rst     (soft_rst),
  .wp_n         (wp_n),
  .op_prog      (op_prog),
  .op_erase     (op_erase),
  .op_bulk      (op_bulk),
  .clr_flags    (clr_flags),
  .sr_wr        (sr_wr),
  .lk_rd_sector (lk_rd_sector),
  .lk_rd_data   (lk_rd_data),
  .st_bp        (st_bp),
  .st_tb        (st_tb),
  .st_swd       (st_swd),
  .sr_refuse    (sr_refuse),
  .op_grant     (op_grant),
  .op_deny      (op_deny),
  .prot_err     (prot_err)
);

// File: tb/test_sector_guard.sv
`timescale 1ns/1ps
module test_sector_guard;
  localparam int SW = 8;
  localparam int NS = 1 << SW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          por_n, soft_rst, wp_n, op_prog, op_erase, op_bulk, clr_flags;
  logic [SW-1:0] op_sector, lk_sector, lk_rd_sector;
  logic          sr_wr, sr_wr_tb, sr_wr_swd, lk_wr;
  logic [3:0]    sr_wr_bp;
  logic [1:0]    lk_wr_data, lk_rd_data;
  logic [3:0]    st_bp;
  logic          st_tb, st_swd, sr_refuse, op_grant, op_deny, prot_err;

  sector_guard #(.SECT_W(SW)) i_sector_guard (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_tag = "R3";

  // reference model
  int m_bp; bit m_tb, m_swd, m_err;
  bit m_wl[NS]; bit m_ld[NS];

  function automatic int reg_cnt(int bp);
    if (bp == 0) return 0;
    if (bp >= 9) return NS;
    return 1 << (bp - 1);
  endfunction

  function automatic bit reg_hit(int bp, bit tb, int s);
    int c = reg_cnt(bp);
    if (tb) return s < c;
    return s >= NS - c;
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic model_clear();
    m_bp = 0; m_tb = 0; m_swd = 0; m_err = 0;
    for (int i = 0; i < NS; i++) begin m_wl[i] = 0; m_ld[i] = 0; end
  endtask

  task automatic idle_in();
    soft_rst = 0; op_prog = 0; op_erase = 0; op_bulk = 0; clr_flags = 0;
    sr_wr = 0; lk_wr = 0; sr_wr_bp = 0; sr_wr_tb = 0; sr_wr_swd = 0;
    lk_wr_data = 0;
  endtask

  // Inputs are set by the caller after a falling edge.
  task automatic step();
    bit rq_s, rq_b, any_wl, den, e_g, e_d, e_r;
    int s;
    rq_b = op_bulk && !soft_rst;
    rq_s = (op_prog || op_erase) && !op_bulk && !soft_rst;
    any_wl = 0;
    for (int i = 0; i < NS; i++) any_wl |= m_wl[i];
    s = int'(op_sector);
    if (rq_b) den = (reg_cnt(m_bp) > 0) || any_wl;
    else      den = rq_s && (reg_hit(m_bp, m_tb, s) || m_wl[s]);
    e_g = (rq_s || rq_b) && !den;
    e_d = den;
    e_r = sr_wr && !soft_rst && m_swd && !wp_n;
    @(posedge clk);
    if (soft_rst) m_err = 0;
    else if (den) m_err = 1;
    else if (clr_flags) m_err = 0;
    if (!soft_rst) begin
      if (sr_wr && !(m_swd && !wp_n)) begin
        m_bp = int'(sr_wr_bp); m_tb = sr_wr_tb; m_swd = sr_wr_swd;
      end
      if (lk_wr) begin
        int k = int'(lk_sector);
        if (!m_ld[k]) m_wl[k] = lk_wr_data[0];
        m_ld[k] = m_ld[k] | lk_wr_data[1];
      end
    end
    @(negedge clk);
    chk({cur_tag, " grant"}, int'(op_grant), int'(e_g));
    chk({cur_tag, " deny"},  int'(op_deny),  int'(e_d));
    chk("R8 prot_err", int'(prot_err), int'(m_err));
    chk("R6 sr_refuse", int'(sr_refuse), int'(e_r));
    chk("R6 status", int'({st_bp, st_tb, st_swd}), (m_bp << 2) | (int'(m_tb) << 1) | int'(m_swd));
    chk("R5 lock readback", int'(lk_rd_data),
        (int'(m_ld[int'(lk_rd_sector)]) << 1) | int'(m_wl[int'(lk_rd_sector)]));
    idle_in();
  endtask

  task automatic wr_status(int bp, bit tb, bit swd);
    sr_wr = 1; sr_wr_bp = 4'(bp); sr_wr_tb = tb; sr_wr_swd = swd;
    step();
  endtask

  task automatic sec_op(int s, string tag);
    cur_tag = tag; op_prog = 1; op_sector = SW'(s); lk_rd_sector = SW'(s);
    step();
    cur_tag = "R3";
  endtask

  task automatic wr_lock(int s, int v);
    lk_wr = 1; lk_sector = SW'(s); lk_wr_data = 2'(v); lk_rd_sector = SW'(s);
    step();
  endtask

  task automatic power_on();
    por_n = 0;
    repeat (3) @(negedge clk);
    model_clear();
    por_n = 1;
    repeat (3) @(negedge clk);
    chk("R11 reset grant", int'(op_grant), 0);
    chk("R11 reset deny", int'(op_deny), 0);
    chk("R11 reset err", int'(prot_err), 0);
    chk("R11 reset status", int'({st_bp, st_tb, st_swd}), 0);
    chk("R11 reset lock", int'(lk_rd_data), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R3 got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle_in(); wp_n = 1; op_sector = 0; lk_sector = 0; lk_rd_sector = 77;
    model_clear();
    power_on();

    // R1 and R2: region size and anchoring sweep
    for (int bp = 0; bp < 16; bp++) begin
      for (int tb = 0; tb < 2; tb++) begin
        wr_status(bp, tb[0], 0);
        begin
          int c = reg_cnt(bp);
          int list[8] = '{0, 1, 255, 254, c % NS, (c + NS - 1) % NS, (NS - c) % NS, (NS - c + NS - 1) % NS};
          foreach (list[i]) sec_op(list[i], tb ? "R2" : "R1");
        end
      end
    end

    // R7: bulk with empty region and no locks, then with one lock
    wr_status(0, 0, 0);
    cur_tag = "R7"; op_bulk = 1; op_prog = 1; step();
    wr_lock(20, 1);
    sec_op(20, "R4");
    cur_tag = "R7"; op_bulk = 1; step();
    // R10: lock clear and program in the same cycle use the old lock
    lk_wr = 1; lk_sector = 20; lk_wr_data = 0; op_prog = 1; op_sector = 20;
    lk_rd_sector = 20; cur_tag = "R10"; step();
    sec_op(20, "R10");
    // R8: denial wins over clr_flags
    wr_lock(30, 1);
    cur_tag = "R8"; op_erase = 1; op_sector = 30; clr_flags = 1; step();
    clr_flags = 1; step();
    // R5: lock-down freezes write lock
    wr_lock(30, 3);
    wr_lock(30, 0);
    wr_lock(30, 2);
    sec_op(30, "R5");
    // R6: frozen status
    wr_status(0, 0, 1);
    wp_n = 0; wr_status(5, 1, 0);
    wp_n = 1; wr_status(5, 1, 0);
    // R9: soft reset ignores requests, keeps locks and status
    sec_op(0, "R9");
    cur_tag = "R9"; soft_rst = 1; op_prog = 1; op_sector = 0; lk_wr = 1;
    lk_sector = 30; lk_wr_data = 0; lk_rd_sector = 30; sr_wr = 1; step();

    // random phase
    for (int n = 0; n < 1500; n++) begin
      int r;
      wp_n = ($urandom % 2) != 0;
      op_prog   = ($urandom % 4) == 0;
      op_erase  = ($urandom % 7) == 0;
      op_bulk   = ($urandom % 20) == 0;
      clr_flags = ($urandom % 10) == 0;
      soft_rst  = ($urandom % 50) == 0;
      r = $urandom % 4;
      op_sector = (r == 0) ? SW'($urandom % 4) : (r == 1) ? SW'(NS - 1 - ($urandom % 4)) : SW'($urandom);
      sr_wr = ($urandom % 10) == 0;
      sr_wr_bp = 4'($urandom); sr_wr_tb = ($urandom % 2) != 0; sr_wr_swd = ($urandom % 3) == 0;
      lk_wr = ($urandom % 7) == 0;
      lk_sector = (($urandom % 2) != 0) ? op_sector : SW'($urandom);
      lk_wr_data = {($urandom % 10) == 0, ($urandom % 3) == 0};
      lk_rd_sector = (($urandom % 2) != 0) ? lk_sector : SW'($urandom);
      cur_tag = "R3";
      step();
    end

    // R11: power-on reset mid-run clears locks and status
    lk_rd_sector = 30;
    power_on();
    sec_op(30, "R11");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule